// File: doc/BRIEF.md
# SPI Interrupt Status Unit

This block gathers per-channel transfer events from up to four SPI channels into one sticky interrupt status register. An enable register gates that status into a single level-sensitive interrupt line. Each channel reports two events: its transmit holding slot has emptied, and its receive holding slot has filled. Each event pulse latches a flag in the status register. Software acknowledges a flag by writing a one to it.

A test path lets software raise every implemented status flag at once without any channel activity. Test mode is a bit in the module control register. The force flag is a bit in the system-test register. The force happens when the second of these two bits becomes set. While both bits stay set, software cannot clear status, so the forced pattern stays in place. The bus protocol, the wakeup logic and the channel data path sit outside this block. The block sees only decoded write strobes with a 32-bit data word, and it returns readback values for its registers.

Top module: `spi_irq_status`

## Requirements
- R1: `irq_o` is high exactly when some bit of (status AND enable) was set in the previous cycle. It is a registered output, so it follows a change in status or enable by one clock.
- R2: A pulse on `tx_empty_evt[n]` sets status bit 4n. A pulse on `rx_full_evt[n]` sets status bit 4n+2. Both bits stay set until cleared.
- R3: A write to the enable register stores only the bits of `wr_data` inside mask 0x1777F. All other enable bits read as zero.
- R4: A write to the status register clears every status bit for which `wr_data` holds a one. It leaves the other status bits unchanged.
- R5: The status write of R4 has no effect when module control bit 3 (test mode) and system-test bit 11 (force) are both set.
- R6: A system-test write with `wr_data[11]` set, while module control bit 3 is already set, sets every status bit in 0x1777F. The system-test register stores only `wr_data[11:0]`.
- R7: A module control write with `wr_data[3]` set, while system-test bit 11 is already set, sets every status bit in 0x1777F. Module control stores only `wr_data[3:0]`.
- R8: If an event pulse and a clearing status write hit the same bit in the same cycle, the bit ends up set.
- R9: After reset, status, enable and system-test read 0, module control reads 0x4 and `irq_o` is low.
- R10: A system-test write with bit 11 set, while module control bit 3 is clear, stores the value and leaves status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_empty_evt | input | NUM_CH | Per-channel transmit-empty event pulse |
| rx_full_evt | input | NUM_CH | Per-channel receive-full event pulse |
| wr_stat | input | 1 | Write strobe, status register (write one to clear) |
| wr_enable | input | 1 | Write strobe, enable register |
| wr_modctl | input | 1 | Write strobe, module control register |
| wr_systest | input | 1 | Write strobe, system-test register |
| wr_data | input | 32 | Write data shared by all strobes |
| stat_o | output | 32 | Status register readback |
| enable_o | output | 32 | Enable register readback |
| modctl_o | output | 4 | Module control readback |
| systest_o | output | 12 | System-test readback |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest state to reach is the locked one, where test mode and the force flag are both set. Only there does a status clear have no effect. The bench enters this state from both orders, writing module control first and then system test, and the reverse, and confirms that each order forces the full pattern. It then tries an all-ones clear in the locked state and checks that nothing changes. Leaving test mode unblocks clearing. A separate pass sets the force bit while test mode is off and confirms that status stays as it was.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int STAT_W     = 17;
    localparam int LANE_W     = 4;
    localparam int MODCTL_W   = 4;
    localparam int SYSTEST_W  = 12;
    localparam int TEST_BIT   = 3;
    localparam int FORCE_BIT  = 11;
    localparam int TXE_OFS    = 0;
    localparam int RXF_OFS    = 2;
    localparam logic [STAT_W-1:0]   IMPL_MASK  = 17'h1777F;
    localparam logic [MODCTL_W-1:0] MODCTL_RST = 4'h4;

    typedef struct packed {
        logic [STAT_W-1:0]    enable;
        logic [MODCTL_W-1:0]  modctl;
        logic [SYSTEST_W-1:0] systest;
    } cfg_t;
endpackage

// File: rtl/spi_irq_evt_map.sv
module spi_irq_evt_map
    import spi_irq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] tx_evt,
    input  logic [NUM_CH-1:0] rx_evt,
    output logic [STAT_W-1:0] set_vec
);
    logic [NUM_CH-1:0][STAT_W-1:0] lane_bits;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        always_comb begin
            lane_bits[g] = '0;
            lane_bits[g][g*LANE_W + TXE_OFS] = tx_evt[g];
            lane_bits[g][g*LANE_W + RXF_OFS] = rx_evt[g];
        end
    end

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            set_vec = set_vec | lane_bits[i];
        end
    end
endmodule

// File: rtl/spi_irq_cfg_regs.sv
module spi_irq_cfg_regs
    import spi_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_enable,
    input  logic        wr_modctl,
    input  logic        wr_systest,
    input  logic [31:0] wr_data,
    output cfg_t        cfg_o,
    output logic        force_o,
    output logic        clr_block_o
);
    cfg_t cfg_d, cfg_q;
    logic force_d;

    always_comb begin
        cfg_d   = cfg_q;
        force_d = 1'b0;
        if (wr_enable) begin
            cfg_d.enable = wr_data[STAT_W-1:0] & IMPL_MASK;
        end
        if (wr_modctl) begin
            cfg_d.modctl = wr_data[MODCTL_W-1:0];
            if (wr_data[TEST_BIT] && cfg_q.systest[FORCE_BIT]) begin
                force_d = 1'b1;
            end
        end
        if (wr_systest) begin
            cfg_d.systest = wr_data[SYSTEST_W-1:0];
            if (wr_data[FORCE_BIT] && cfg_q.modctl[TEST_BIT]) begin
                force_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.enable  <= '0;
            cfg_q.modctl  <= MODCTL_RST;
            cfg_q.systest <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o       = cfg_q;
    assign force_o     = force_d;
    assign clr_block_o = cfg_q.modctl[TEST_BIT] & cfg_q.systest[FORCE_BIT];
endmodule

// File: rtl/spi_irq_stat_reg.sv
module spi_irq_stat_reg
    import spi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec,
    input  logic              wr_stat,
    input  logic [31:0]       wr_data,
    input  logic              clr_block,
    input  logic              force_all,
    output logic [STAT_W-1:0] stat_o
);
    logic [STAT_W-1:0] stat_d, stat_q;
    logic [STAT_W-1:0] clr_vec;

    always_comb begin
        clr_vec = '0;
        if (wr_stat && !clr_block) begin
            clr_vec = wr_data[STAT_W-1:0];
        end
        // set sources are applied after the clear so an event wins
        stat_d = (stat_q & ~clr_vec) | (set_vec & IMPL_MASK);
        if (force_all) begin
            stat_d = stat_d | IMPL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] tx_empty_evt,
    input  logic [NUM_CH-1:0] rx_full_evt,
    input  logic              wr_stat,
    input  logic              wr_enable,
    input  logic              wr_modctl,
    input  logic              wr_systest,
    input  logic [31:0]       wr_data,
    output logic [31:0]       stat_o,
    output logic [31:0]       enable_o,
    output logic [3:0]        modctl_o,
    output logic [11:0]       systest_o,
    output logic              irq_o
);
    localparam int PAD_W = 32 - STAT_W;

    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] stat_q;
    cfg_t              cfg;
    logic              force_all;
    logic              clr_block;
    logic              irq_d, irq_q;

    spi_irq_evt_map #(.NUM_CH(NUM_CH)) u_map (
        .tx_evt  (tx_empty_evt),
        .rx_evt  (rx_full_evt),
        .set_vec (set_vec)
    );

    spi_irq_cfg_regs u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_enable   (wr_enable),
        .wr_modctl   (wr_modctl),
        .wr_systest  (wr_systest),
        .wr_data     (wr_data),
        .cfg_o       (cfg),
        .force_o     (force_all),
        .clr_block_o (clr_block)
    );

    spi_irq_stat_reg u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .wr_stat   (wr_stat),
        .wr_data   (wr_data),
        .clr_block (clr_block),
        .force_all (force_all),
        .stat_o    (stat_q)
    );

    always_comb begin
        irq_d = |(stat_q & cfg.enable);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign stat_o    = {{PAD_W{1'b0}}, stat_q};
    assign enable_o  = {{PAD_W{1'b0}}, cfg.enable};
    assign modctl_o  = cfg.modctl;
    assign systest_o = cfg.systest;
    assign irq_o     = irq_q;
endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] tx_empty_evt,
    input logic [NUM_CH-1:0] rx_full_evt,
    input logic              wr_stat,
    input logic              wr_enable,
    input logic              wr_systest,
    input logic [31:0]       wr_data,
    input logic [31:0]       stat_o,
    input logic [31:0]       enable_o,
    input logic [3:0]        modctl_o,
    input logic [11:0]       systest_o,
    input logic              irq_o
);
    localparam logic [31:0] FULL = 32'h0001777F;
    logic [31:0] evt_bits;

    always_comb begin
        evt_bits = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            evt_bits[4*i]     = tx_empty_evt[i];
            evt_bits[4*i + 2] = rx_full_evt[i];
        end
    end

    // R1
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(stat_o & enable_o))));

    // R2
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_bits != 0) |=> ((stat_o & $past(evt_bits)) == $past(evt_bits)));

    // R3
    enable_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enable |=> (enable_o == ($past(wr_data) & FULL)));

    // R5
    clear_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (modctl_o[3] && systest_o[11]) |=> (($past(stat_o) & ~stat_o) == 0));

    // R6
    systest_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_systest && wr_data[11] && modctl_o[3]) |=> ((stat_o & FULL) == FULL));
endmodule

bind spi_irq_status spi_irq_status_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_empty_evt (tx_empty_evt),
    .rx_full_evt  (rx_full_evt),
    .wr_stat      (wr_stat),
    .wr_enable    (wr_enable),
    .wr_systest   (wr_systest),
    .wr_data      (wr_data),
    .stat_o       (stat_o),
    .enable_o     (enable_o),
    .modctl_o     (modctl_o),
    .systest_o    (systest_o),
    .irq_o        (irq_o)
);

// File: tb/sim_spi_irq_status.sv
module sim_spi_irq_status;
    localparam int NCH = 4;
    localparam logic [31:0] FULL = 32'h0001777F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] tx_evt = '0;
    logic [NCH-1:0] rx_evt = '0;
    logic wr_stat = 0, wr_enable = 0, wr_modctl = 0, wr_systest = 0;
    logic [31:0] wr_data = '0;
    logic [31:0] stat_o, enable_o;
    logic [3:0]  modctl_o;
    logic [11:0] systest_o;
    logic        irq_o;
    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    spi_irq_status #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_empty_evt(tx_evt), .rx_full_evt(rx_evt),
        .wr_stat(wr_stat), .wr_enable(wr_enable), .wr_modctl(wr_modctl),
        .wr_systest(wr_systest), .wr_data(wr_data), .stat_o(stat_o),
        .enable_o(enable_o), .modctl_o(modctl_o), .systest_o(systest_o),
        .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kind: 0 status, 1 enable, 2 modctl, 3 systest
    task automatic wr(input int kind, input logic [31:0] d);
        @(negedge clk);
        wr_data    = d;
        wr_stat    = (kind == 0);
        wr_enable  = (kind == 1);
        wr_modctl  = (kind == 2);
        wr_systest = (kind == 3);
        @(negedge clk);
        wr_stat = 0; wr_enable = 0; wr_modctl = 0; wr_systest = 0;
    endtask

    task automatic pulse(input logic [NCH-1:0] t, input logic [NCH-1:0] r);
        @(negedge clk);
        tx_evt = t; rx_evt = r;
        @(negedge clk);
        tx_evt = '0; rx_evt = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 stat", stat_o, 0);
        chk("R9 enable", enable_o, 0);
        chk("R9 modctl", {28'd0, modctl_o}, 32'h4);
        chk("R9 systest", {20'd0, systest_o}, 0);
        chk("R9 irq", {31'd0, irq_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 each channel and event type alone
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < 2; k++) begin
                if (k == 0) pulse(NCH'(1 << c), '0);
                else        pulse('0, NCH'(1 << c));
                chk("R2 event bit", stat_o, 32'(1) << (4*c + 2*k));
                wr(0, 32'hFFFFFFFF);
                chk("R4 clear all", stat_o, 0);
            end
        end

        // R3 enable mask, one bit at a time over the full word
        for (int b = 0; b < 32; b++) begin
            wr(1, 32'(1) << b);
            chk("R3 enable bit", enable_o, (32'(1) << b) & FULL);
        end
        wr(1, 32'hFFFFFFFF);
        chk("R3 enable all", enable_o, FULL);

        // R4 partial clear leaves other bits
        pulse(4'hF, 4'hF);
        chk("R2 all events", stat_o, 32'h00005555);
        wr(0, 32'h00000104);
        chk("R4 partial clear", stat_o, 32'h00005451);
        wr(0, 32'hFFFFFFFF);

        // R1 irq latency and gating per event bit
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < 2; k++) begin
                int bitn;
                bitn = 4*c + 2*k;
                wr(1, 0);
                @(negedge clk);
                if (k == 0) pulse(NCH'(1 << c), '0);
                else        pulse('0, NCH'(1 << c));
                @(negedge clk);
                chk("R1 irq masked", {31'd0, irq_o}, 0);
                wr(1, 32'(1) << bitn);
                chk("R1 irq one cycle late", {31'd0, irq_o}, 0);
                @(negedge clk);
                chk("R1 irq high", {31'd0, irq_o}, 1);
                wr(0, 32'(1) << bitn);
                @(negedge clk);
                chk("R1 irq drops", {31'd0, irq_o}, 0);
            end
        end
        wr(1, 0);

        // R8 event beats clear on the same bit
        pulse(4'b0010, 4'b0000);
        @(negedge clk);
        wr_data = 32'hFFFFFFFF; wr_stat = 1; tx_evt = 4'b0010;
        @(negedge clk);
        wr_stat = 0; tx_evt = '0;
        chk("R8 event wins", stat_o, 32'h00000010);
        wr(0, 32'hFFFFFFFF);

        // R10 force bit without test mode
        pulse(4'b0001, 4'b0000);
        wr(3, 32'h0000F800);
        chk("R10 systest stored low 12", {20'd0, systest_o}, 32'h800);
        chk("R10 no force", stat_o, 32'h1);
        wr(3, 0);

        // R6 test mode first, then force bit
        wr(2, 32'hFFFFFFFC);
        chk("R7 modctl low 4", {28'd0, modctl_o}, 32'hC);
        chk("R7 no force without systest", stat_o, 32'h1);
        wr(3, 32'h00000800);
        chk("R6 force all", stat_o, FULL);
        // R5 clear blocked
        wr(0, 32'hFFFFFFFF);
        chk("R5 clear blocked", stat_o, FULL);
        // leave test mode: clear works again
        wr(2, 32'h4);
        wr(0, 32'hFFFFFFFF);
        chk("R4 clear after test", stat_o, 0);

        // R7 force bit first, then test mode
        wr(2, 32'h8);
        chk("R7 force via modctl", stat_o, FULL);
        wr(0, 32'h1);
        chk("R5 single clear blocked", stat_o, FULL);
        wr(3, 0);
        wr(0, 32'h00010001);
        chk("R4 clear after unlock", stat_o, FULL & ~32'h00010001);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule